// File: doc/BRIEF.md
# Pruned Soft-Output Viterbi Metric Unit

This block performs the forward recursion of a soft-output Viterbi decoder for the four-state trellis of the rate-1/2 recursive systematic code with feedback polynomial 7 and feed-forward polynomial 5. On each accepted trellis step it takes three signed soft values: a systematic sample, a parity sample and an a-priori value. From these it extends every live path. Each state then keeps the stronger of its two incoming candidates.

For every state the unit reports the input bit of the winning branch and the size of the margin by which it won. A traceback stage downstream uses these to build soft outputs. After the add-compare-select step the unit prunes the trellis. A path is dropped when its new metric is not above the previous stage's best metric plus a non-positive threshold. Of the paths that remain, only a capped number with the highest metrics are kept. The mask of survivors and the index of the strongest survivor are also reported to the traceback stage.

Metrics are stored relative to the previous stage's best value, so they stay bounded without any periodic rescaling. A new frame is opened by raising a start flag together with a step. This places the recursion back at the all-zero encoder state.

Top module: `pruned_sova_fwd`

## Requirements
- R1: After reset, outValid, decOut, deltaOut, survOut and bestState are all zero. The stored trellis state equals a frame start: only state 0 is live, with metric 0.
- R2: The branch candidate is prev + sys·xs + par·xp ± h. Here xs and xp are the branch's systematic and parity bits mapped 0→-1 and 1→+1, and h = aprIn arithmetically shifted right by one. The h term is added for input bit 1 and subtracted for input bit 0.
- R3: The state index is {r1,r2}, with r1 the newest register bit. For input u, the feedback bit is a = u^r1^r2, the parity bit is a^r2 and the next state is {a,r1}. With noiseless inputs (±8 per bit) from that encoder, bestState tracks the encoder state.
- R4: Each state selects its larger candidate, and a tie goes to the input-0 candidate. decOut[i] is the input bit of the winner. deltaOut field i (bits i·DW upward) is |c1−c0| saturated to 2^DW−1. It is all ones when only one candidate comes from a live state, and zero when none does.
- R5: The new metric of a state is its winner minus the maximum over live states of the previous stage. The state may survive only if that value is strictly greater than THRESH.
- R6: At most NMAX states survive. Among the states passing the threshold, higher metrics win, and on equal metrics the lower index wins.
- R7: If no state passes the threshold, exactly one state survives: the one with the highest metric among states with a live predecessor, with the lower index on a tie.
- R8: frameStart, when raised with inValid, makes that step start from state 0 at metric 0 with all other states dead, whatever was stored before.
- R9: Outputs are registered. outValid is high in the cycle after an accepted step. Without inValid, outValid is low and all outputs and stored metrics hold.
- R10: bestState is the index of the survivor with the highest metric, with the lower index on a tie.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Accept one trellis step |
| frameStart | input | 1 | With inValid: restart from the zero state |
| sysIn | input | IN_W | Signed systematic soft value |
| parIn | input | IN_W | Signed parity soft value |
| aprIn | input | IN_W | Signed a-priori value |
| outValid | output | 1 | Step results valid |
| decOut | output | 4 | Winning input bit per state |
| deltaOut | output | 4·DW | Metric margin per state, field i at bits i·DW |
| survOut | output | 4 | Surviving-state mask |
| bestState | output | 2 | Index of the strongest survivor |

## Verification
The properties assume a non-positive THRESH and an NMAX of at least one. They also assume that frameStart has meaning only alongside inValid. The stimulus keeps soft magnitudes small enough that the relative metrics never approach the stored-width limits, so saturation never alters which state wins or survives. Tests that depend on stored history start with frameStart or follow directly from reset, and a second instance with THRESH of zero is the only way the empty-threshold fallback is reached. Idle gaps are placed between steps so that the hold behaviour is observed at the ports.

// File: rtl/psova_pkg.sv
`timescale 1ns/1ps
package psova_pkg;
  localparam int NSTATE = 4;
  localparam int SW     = 2;

  typedef struct packed {
    logic step;   // accept a trellis step this cycle
    logic fresh;  // this step starts a new frame
  } psovaStrobe_t;
endpackage

// File: rtl/psova_ctrl.sv
`timescale 1ns/1ps
module psova_ctrl
  import psova_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic         frameStart,
  output psovaStrobe_t strobes,
  output logic         outValid
);
  always_comb begin
    strobes.step  = inValid;
    strobes.fresh = inValid & frameStart;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end
endmodule

// File: rtl/psova_acs.sv
`timescale 1ns/1ps
module psova_acs #(
  parameter int IN_W = 6,
  parameter int METW = 12,
  parameter int CW   = 15,
  parameter int DW   = 8,
  parameter int NEXT = 0
) (
  input  logic signed [METW-1:0] metA,   // predecessor with r2 = 0
  input  logic signed [METW-1:0] metB,   // predecessor with r2 = 1
  input  logic                   valA,
  input  logic                   valB,
  input  logic signed [IN_W-1:0] sysV,
  input  logic signed [IN_W-1:0] parV,
  input  logic signed [IN_W-1:0] halfV,
  output logic signed [CW-1:0]   winMet,
  output logic                   winDec,
  output logic [DW-1:0]          winDelta,
  output logic                   winValid
);
  localparam int U_A = ((NEXT >> 1) ^ NEXT) & 1;
  localparam int P_A = (NEXT >> 1) & 1;
  localparam logic signed [CW-1:0] DMAXC = CW'((2 ** DW) - 1);

  function automatic logic signed [CW-1:0] signTerm(input logic signed [IN_W-1:0] v,
                                                    input bit pos);
    return pos ? CW'(v) : -CW'(v);
  endfunction

  logic signed [CW-1:0] candA, candB, c0, c1, diff, absDiff;
  logic v0, v1;

  always_comb begin
    candA = CW'(metA) + signTerm(sysV, U_A == 1) + signTerm(parV, P_A == 1)
          + signTerm(halfV, U_A == 1);
    candB = CW'(metB) + signTerm(sysV, U_A == 0) + signTerm(parV, P_A == 0)
          + signTerm(halfV, U_A == 0);
    if (U_A == 0) begin
      c0 = candA; v0 = valA; c1 = candB; v1 = valB;
    end else begin
      c0 = candB; v0 = valB; c1 = candA; v1 = valA;
    end
    diff    = c1 - c0;
    absDiff = (diff < 0) ? -diff : diff;
    winValid = v0 | v1;
    if (v0 && v1) begin
      winDec   = (c1 > c0);
      winMet   = winDec ? c1 : c0;
      winDelta = (absDiff > DMAXC) ? DW'(DMAXC) : DW'(absDiff);
    end else if (v1) begin
      winDec = 1'b1; winMet = c1; winDelta = '1;
    end else if (v0) begin
      winDec = 1'b0; winMet = c0; winDelta = '1;
    end else begin
      winDec = 1'b0; winMet = c0; winDelta = '0;
    end
  end
endmodule

// File: rtl/psova_dpath.sv
`timescale 1ns/1ps
module psova_dpath
  import psova_pkg::*;
#(
  parameter int IN_W   = 6,
  parameter int METW   = 12,
  parameter int DW     = 8,
  parameter int NMAX   = 3,
  parameter int THRESH = -2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  psovaStrobe_t             strobes,
  input  logic signed [IN_W-1:0]   sysIn,
  input  logic signed [IN_W-1:0]   parIn,
  input  logic signed [IN_W-1:0]   aprIn,
  output logic [NSTATE-1:0]        decOut,
  output logic [NSTATE*DW-1:0]     deltaOut,
  output logic [NSTATE-1:0]        survOut,
  output logic [SW-1:0]            bestState
);
  localparam int CW = METW + 3;
  localparam logic signed [METW-1:0] MET_MIN = {1'b1, {(METW-1){1'b0}}};
  localparam logic signed [METW-1:0] MET_MAX = {1'b0, {(METW-1){1'b1}}};

  logic signed [METW-1:0] metReg [NSTATE];
  logic [NSTATE-1:0]      valReg;
  logic signed [METW-1:0] srcMet [NSTATE];
  logic [NSTATE-1:0]      srcVal;
  logic signed [METW-1:0] prevMax;
  logic signed [IN_W-1:0] halfApr;

  logic signed [CW-1:0]   winMet [NSTATE];
  logic signed [CW-1:0]   norm   [NSTATE];
  logic [NSTATE-1:0]      winDec, winValid, passT, keepCap, keep;
  logic [NSTATE-1:0][DW-1:0] winDelta;
  logic [SW-1:0]          fbIdx, bestIdx;
  logic signed [METW-1:0] metNext [NSTATE];

  assign halfApr = aprIn >>> 1;

  // source metrics: stored history or a fresh frame from the zero state
  always_comb begin
    for (int i = 0; i < NSTATE; i++) begin
      srcMet[i] = strobes.fresh ? ((i == 0) ? '0 : MET_MIN) : metReg[i];
      srcVal[i] = strobes.fresh ? (i == 0) : valReg[i];
    end
    prevMax = MET_MIN;
    for (int i = 0; i < NSTATE; i++)
      if (srcVal[i] && srcMet[i] > prevMax) prevMax = srcMet[i];
  end

  for (genvar g = 0; g < NSTATE; g++) begin : g_acs
    localparam int PA = (g % 2) * 2;
    psova_acs #(.IN_W(IN_W), .METW(METW), .CW(CW), .DW(DW), .NEXT(g)) i_acs (
      .metA(srcMet[PA]), .metB(srcMet[PA+1]),
      .valA(srcVal[PA]), .valB(srcVal[PA+1]),
      .sysV(sysIn), .parV(parIn), .halfV(halfApr),
      .winMet(winMet[g]), .winDec(winDec[g]),
      .winDelta(winDelta[g]), .winValid(winValid[g])
    );
    assign norm[g]  = winMet[g] - CW'(prevMax);
    assign passT[g] = winValid[g] && (norm[g] > CW'(THRESH));
  end

  // survivor cap by rank, fallback and strongest survivor
  always_comb begin
    for (int i = 0; i < NSTATE; i++) begin
      int cnt;
      cnt = 0;
      for (int j = 0; j < NSTATE; j++)
        if (j != i && passT[j] &&
            (norm[j] > norm[i] || (norm[j] == norm[i] && j < i)))
          cnt++;
      keepCap[i] = passT[i] && (cnt < NMAX);
    end
    fbIdx = '0;
    for (int i = NSTATE - 1; i >= 0; i--)
      if (winValid[i] && (!winValid[fbIdx] || norm[i] >= norm[fbIdx] || fbIdx == 0))
        if (!winValid[fbIdx] || norm[i] >= norm[fbIdx]) fbIdx = SW'(i);
    keep = (|passT) ? keepCap : (NSTATE'(1) << fbIdx);
    bestIdx = '0;
    for (int i = NSTATE - 1; i >= 0; i--)
      if (keep[i] && (!keep[bestIdx] || norm[i] >= norm[bestIdx])) bestIdx = SW'(i);
    for (int i = 0; i < NSTATE; i++) begin
      if (!keep[i])                    metNext[i] = MET_MIN;
      else if (norm[i] > CW'(MET_MAX)) metNext[i] = MET_MAX;
      else if (norm[i] < CW'(MET_MIN)) metNext[i] = MET_MIN;
      else                             metNext[i] = METW'(norm[i]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NSTATE; i++) metReg[i] <= (i == 0) ? '0 : MET_MIN;
      valReg    <= NSTATE'(1);
      decOut    <= '0;
      deltaOut  <= '0;
      survOut   <= '0;
      bestState <= '0;
    end else if (strobes.step) begin
      for (int i = 0; i < NSTATE; i++) metReg[i] <= metNext[i];
      valReg    <= keep;
      decOut    <= winDec;
      deltaOut  <= winDelta;
      survOut   <= keep;
      bestState <= bestIdx;
    end
  end
endmodule

// File: rtl/pruned_sova_fwd.sv
`timescale 1ns/1ps
module pruned_sova_fwd
  import psova_pkg::*;
#(
  parameter int IN_W   = 6,
  parameter int METW   = 12,
  parameter int DW     = 8,
  parameter int NMAX   = 3,
  parameter int THRESH = -2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   inValid,
  input  logic                   frameStart,
  input  logic signed [IN_W-1:0] sysIn,
  input  logic signed [IN_W-1:0] parIn,
  input  logic signed [IN_W-1:0] aprIn,
  output logic                   outValid,
  output logic [NSTATE-1:0]      decOut,
  output logic [NSTATE*DW-1:0]   deltaOut,
  output logic [NSTATE-1:0]      survOut,
  output logic [SW-1:0]          bestState
);
  psovaStrobe_t strobes;

  psova_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .frameStart(frameStart),
    .strobes(strobes), .outValid(outValid)
  );

  psova_dpath #(.IN_W(IN_W), .METW(METW), .DW(DW), .NMAX(NMAX), .THRESH(THRESH)) i_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .sysIn(sysIn), .parIn(parIn), .aprIn(aprIn),
    .decOut(decOut), .deltaOut(deltaOut), .survOut(survOut), .bestState(bestState)
  );
endmodule

// File: rtl/psova_checker.sv
`timescale 1ns/1ps
module psova_checker #(
  parameter int NMAX = 3,
  parameter int DW   = 8
) (
  input logic          clk,
  input logic          rstN,
  input logic          inValid,
  input logic          outValid,
  input logic [3:0]    decOut,
  input logic [4*DW-1:0] deltaOut,
  input logic [3:0]    survOut,
  input logic [1:0]    bestState
);
  a_r9_step_valid: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && $stable(survOut) && $stable(decOut)
                  && $stable(deltaOut) && $stable(bestState)));

  a_r6_survivor_cap: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ($countones(survOut) <= NMAX));

  a_r7_never_empty: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (survOut != 4'b0000));

  a_r10_best_is_live: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> survOut[bestState]);
endmodule

bind pruned_sova_fwd psova_checker #(.NMAX(NMAX), .DW(DW)) i_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .outValid(outValid),
  .decOut(decOut), .deltaOut(deltaOut), .survOut(survOut), .bestState(bestState)
);

// File: tb/test_pruned_sova_fwd.sv
`timescale 1ns/1ps
module test_pruned_sova_fwd;
  localparam int IN_W = 6;
  localparam int DW   = 8;
  localparam int NMAX_B = 3;
  localparam int T_B    = -2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, frameStart = 1'b0;
  logic signed [IN_W-1:0] sysIn = '0, parIn = '0, aprIn = '0;
  logic outValid, outValidZ;
  logic [3:0] decOut, survOut, decOutZ, survOutZ;
  logic [4*DW-1:0] deltaOut, deltaOutZ;
  logic [1:0] bestState, bestStateZ;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pruned_sova_fwd #(.IN_W(IN_W), .DW(DW), .NMAX(NMAX_B), .THRESH(T_B)) i_pruned_sova_fwd (
    .clk(clk), .rstN(rstN), .inValid(inValid), .frameStart(frameStart),
    .sysIn(sysIn), .parIn(parIn), .aprIn(aprIn),
    .outValid(outValid), .decOut(decOut), .deltaOut(deltaOut),
    .survOut(survOut), .bestState(bestState));

  pruned_sova_fwd #(.IN_W(IN_W), .DW(DW), .NMAX(NMAX_B), .THRESH(0)) i_pruned_sova_fwd_zt (
    .clk(clk), .rstN(rstN), .inValid(inValid), .frameStart(frameStart),
    .sysIn(sysIn), .parIn(parIn), .aprIn(aprIn),
    .outValid(outValidZ), .decOut(decOutZ), .deltaOut(deltaOutZ),
    .survOut(survOutZ), .bestState(bestStateZ));

  // bench model of the main instance
  int  mM[4];
  bit  mV[4];
  int  eDec[4], eDelta[4], eSurv, eBest;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic modelStep(input bit fs, input int s, input int p, input int a);
    int srcM[4]; bit srcV[4];
    int c[4][2]; bit cv[4][2];
    int win[4], nrm[4]; bit wv[4], pass[4], keep[4];
    int prevMax, h, fb, anyPass, best;
    h = a >>> 1;
    for (int i = 0; i < 4; i++) begin
      srcM[i] = fs ? 0 : mM[i];
      srcV[i] = fs ? (i == 0) : mV[i];
      cv[i][0] = 0; cv[i][1] = 0; c[i][0] = 0; c[i][1] = 0;
    end
    prevMax = -1000000;
    for (int i = 0; i < 4; i++) if (srcV[i] && srcM[i] > prevMax) prevMax = srcM[i];
    for (int ps = 0; ps < 4; ps++) begin
      if (srcV[ps]) begin
        for (int u = 0; u < 2; u++) begin
          int r1, r2, fbk, pb, ns;
          r1 = (ps >> 1) & 1; r2 = ps & 1;
          fbk = u ^ r1 ^ r2; pb = fbk ^ r2; ns = fbk * 2 + r1;
          c[ns][u] = srcM[ps] + (u ? s : -s) + (pb ? p : -p) + (u ? h : -h);
          cv[ns][u] = 1;
        end
      end
    end
    for (int i = 0; i < 4; i++) begin
      wv[i] = cv[i][0] | cv[i][1];
      if (cv[i][0] && cv[i][1]) begin
        int d;
        eDec[i] = (c[i][1] > c[i][0]);
        win[i]  = eDec[i] ? c[i][1] : c[i][0];
        d = c[i][1] - c[i][0]; if (d < 0) d = -d;
        eDelta[i] = (d > 255) ? 255 : d;
      end else if (cv[i][1]) begin
        eDec[i] = 1; win[i] = c[i][1]; eDelta[i] = 255;
      end else if (cv[i][0]) begin
        eDec[i] = 0; win[i] = c[i][0]; eDelta[i] = 255;
      end else begin
        eDec[i] = 0; win[i] = 0; eDelta[i] = 0;
      end
      nrm[i]  = win[i] - prevMax;
      pass[i] = wv[i] && (nrm[i] > T_B);
    end
    anyPass = 0;
    for (int i = 0; i < 4; i++) if (pass[i]) anyPass = 1;
    for (int i = 0; i < 4; i++) begin
      int above; above = 0;
      for (int j = 0; j < 4; j++)
        if (j != i && pass[j] && (nrm[j] > nrm[i] || (nrm[j] == nrm[i] && j < i))) above++;
      keep[i] = pass[i] && (above < NMAX_B);
    end
    if (anyPass == 0) begin
      fb = -1;
      for (int i = 0; i < 4; i++) if (wv[i] && (fb < 0 || nrm[i] > nrm[fb])) fb = i;
      for (int i = 0; i < 4; i++) keep[i] = (i == fb);
    end
    best = -1; eSurv = 0;
    for (int i = 0; i < 4; i++) begin
      if (keep[i]) begin
        eSurv += (1 << i);
        if (best < 0 || nrm[i] > nrm[best]) best = i;
      end
      mM[i] = nrm[i]; mV[i] = keep[i];
    end
    eBest = best;
  endtask

  task automatic doStep(input bit fs, input int s, input int p, input int a, input string tag);
    @(negedge clk);
    sysIn = s[IN_W-1:0]; parIn = p[IN_W-1:0]; aprIn = a[IN_W-1:0];
    frameStart = fs; inValid = 1'b1;
    modelStep(fs, s, p, a);
    @(negedge clk);
    inValid = 1'b0; frameStart = 1'b0;
    chk({tag, " R9 outValid"}, int'(outValid), 1);
    chk({tag, " R4 decOut"}, int'(decOut), eDec[0] + 2*eDec[1] + 4*eDec[2] + 8*eDec[3]);
    chk({tag, " R6 survOut"}, int'(survOut), eSurv);
    chk({tag, " R10 bestState"}, int'(bestState), eBest);
    for (int i = 0; i < 4; i++)
      chk({tag, " R4 deltaOut"}, int'(deltaOut[i*DW +: DW]), eDelta[i]);
  endtask

  task automatic tReset;
    chk("R1 outValid", int'(outValid), 0);
    chk("R1 decOut", int'(decOut), 0);
    chk("R1 deltaOut", int'(deltaOut), 0);
    chk("R1 survOut", int'(survOut), 0);
    chk("R1 bestState", int'(bestState), 0);
  endtask

  // first steps after reset without frameStart: start from state 0, cap, ties
  task automatic tZeroFrame;
    doStep(0, 0, 0, 0, "R1 first step");
    chk("R1 survivors from state 0", int'(survOut), 4'b0101);
    doStep(0, 0, 0, 0, "R6 cap");
    chk("R6 cap drops state 3", int'(survOut), 4'b0111);
    doStep(0, 0, 0, 0, "R4 tie");
    chk("R4 tie keeps input 0 at state 0", int'(decOut[0]), 0);
    chk("R4 tie delta zero at state 0", int'(deltaOut[DW-1:0]), 0);
  endtask

  // noiseless codeword: best state follows the encoder
  task automatic tCodeword;
    int bits[10] = '{1, 0, 1, 1, 0, 0, 1, 0, 1, 1};
    int es = 0;
    for (int k = 0; k < 10; k++) begin
      int r1, r2, fbk, pb;
      r1 = (es >> 1) & 1; r2 = es & 1;
      fbk = bits[k] ^ r1 ^ r2; pb = fbk ^ r2;
      doStep(k == 0, bits[k] ? 8 : -8, pb ? 8 : -8, 0, "R3 codeword");
      es = fbk * 2 + r1;
      chk("R3 bestState tracks encoder", int'(bestState), es);
    end
  endtask

  task automatic tApriori;
    doStep(1, 0, 0, 20, "R2 apriori plus");
    chk("R2 positive apriori favours input 1", int'(survOut), 4'b0100);
    doStep(1, 0, 0, -5, "R2 apriori odd negative");
    chk("R2 negative apriori favours input 0", int'(survOut), 4'b0001);
    doStep(0, 3, -4, 7, "R2 mixed");
    doStep(0, -6, 5, -9, "R2 mixed");
  endtask

  task automatic tThreshold;
    doStep(1, 1, 0, 0, "R5 near threshold");
    chk("R5 margin -1 above T survives", int'(survOut), 4'b0101);
    doStep(0, 3, 2, 0, "R5 prune");
    doStep(0, -2, 6, 1, "R5 prune");
    doStep(0, 10, -10, 4, "R5 prune");
  endtask

  task automatic tFallback;
    doStep(1, 0, 0, 0, "R7 zero step");
    chk("R7 fallback survOut zt", int'(survOutZ), 4'b0001);
    chk("R7 fallback best zt", int'(bestStateZ), 0);
    doStep(1, 4, 0, 0, "R7 pass step");
    chk("R7 pass survOut zt", int'(survOutZ), 4'b0100);
    chk("R7 pass best zt", int'(bestStateZ), 2);
    doStep(0, 0, 0, 0, "R7 tie step");
    chk("R7 tie fallback survOut zt", int'(survOutZ), 4'b0010);
    chk("R7 tie fallback best zt", int'(bestStateZ), 1);
  endtask

  task automatic tHold;
    logic [3:0] sv; logic [4*DW-1:0] dv; logic [3:0] dc; logic [1:0] bs;
    doStep(1, 5, -3, 2, "R9 before idle");
    sv = survOut; dv = deltaOut; dc = decOut; bs = bestState;
    @(negedge clk); @(negedge clk);
    chk("R9 idle outValid low", int'(outValid), 0);
    chk("R9 idle survOut held", int'(survOut), int'(sv));
    chk("R9 idle deltaOut held", int'(deltaOut == dv), 1);
    chk("R9 idle decOut held", int'(decOut), int'(dc));
    chk("R9 idle bestState held", int'(bestState), int'(bs));
    frameStart = 1'b1;
    @(negedge clk); frameStart = 1'b0;
    chk("R8 frameStart alone ignored", int'(outValid), 0);
    doStep(0, 2, 2, 0, "R9 after idle");
  endtask

  task automatic tRestart;
    doStep(0, 7, 7, 3, "R8 history");
    doStep(1, 0, 0, 0, "R8 restart");
    chk("R8 restart survivors", int'(survOut), 4'b0101);
    chk("R8 restart delta single", int'(deltaOut[2*DW +: DW]), 255);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin mM[i] = 0; mV[i] = (i == 0); end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset;
    tZeroFrame;
    tCodeword;
    tApriori;
    tThreshold;
    tFallback;
    tHold;
    tRestart;
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule